// File: doc/BRIEF.md
# Two-Slot Frame Serial Audio Port

This block is the serial side of a stereo audio converter pair. It moves one 16-bit sample in each direction per frame, between parallel converter-side words and a four-wire bit-serial link. The link carries a bit clock, a frame marker, a serial input line and a serial output line. Every frame is 32 bit-clock periods long and has two 16-bit slots. A control input selects which slot carries the data. In that slot the outgoing word leaves the chip and the incoming word is collected.

All logic runs on the master clock `mclk`. As bus follower (slave), the port takes the bit clock and frame marker from outside. Both pass through two-flop synchronisers, and the rising and falling edges of the synchronised bit clock become one-cycle strobes. As bus leader (master), the port makes the bit clock from `mclk` through a divider of 1, 2 or 4 with a fixed 8:1 ratio, so one frame lasts 256 × divider master clocks. The frame marker can be a one-bit pulse placed before the first bit (short) or a level held for the first slot (long). The leader always uses the long form. A loopback switch sends the outgoing word straight to the parallel receive output, so a whole system can be tested on the board without the far end.

Top module: `audio_serial_port`

## Requirements
- R1: While `rst_n` is low, and on release, `sdo_oe`, `dac_valid`, `bclk_out` and `fsync_out` are 0. All-zero control inputs select follower mode, short marker, slot 0, divider 1 and no loopback.
- R2: A frame has bit positions 0..31, with position 0 the first data bit. `cfg_slot`=0 selects positions 0..15 and `cfg_slot`=1 selects positions 16..31. `sdo_oe` is 1 only in the selected positions of a frame that started after reset.
- R3: The word shifted out on `sdo` is the value of `adc_data` captured when the frame starts. It goes out most significant bit first, one bit per bit clock. `sdo` changes only after a rising bit-clock edge, so it is stable at the falling edge.
- R4: `sdi` is sampled on falling bit-clock edges in the selected slot. After the slot's last bit, the 16-bit word (first bit as MSB) appears on `dac_data` with `dac_valid` high for exactly one `mclk` cycle.
- R5: With follower mode and `cfg_long_fs`=0, a frame marker that is high for one bit period makes the next bit period position 0.
- R6: With follower mode and `cfg_long_fs`=1, the bit period in which the marker rises from low to high is position 0. The marker stays high for positions 0..15.
- R7: In leader mode (`cfg_master`=1), `bclk_out` has a period of 8×D `mclk` cycles. D is 1, 2 or 4 for `cfg_div` equal to 0, 1 or 2, and code 3 also gives D=4.
- R8: In leader mode, `fsync_out` uses the long form whatever `cfg_long_fs` is. It rises together with `bclk_out`, is high for 16 of the 32 bit periods, and repeats every 256×D `mclk` cycles.
- R9: With `cfg_loopback`=1, each `dac_data` word equals the frame's captured `adc_data` word, and `sdi` has no effect.
- R10: `port_drive` equals `cfg_master`. In follower mode, `bclk_out` and `fsync_out` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock; every register runs on it |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_master | input | 1 | 1 = port makes the bit clock and frame marker |
| cfg_long_fs | input | 1 | Follower marker form: 0 short pulse, 1 long level |
| cfg_slot | input | 1 | Data slot: 0 first half of frame, 1 second half |
| cfg_div | input | 2 | Leader divider code: 0 →1, 1 →2, 2 or 3 →4 |
| cfg_loopback | input | 1 | 1 = receive word comes from the transmit word |
| bclk_in | input | 1 | External bit clock in follower mode |
| fsync_in | input | 1 | External frame marker in follower mode |
| sdi | input | 1 | Serial data into the port |
| bclk_out | output | 1 | Generated bit clock (leader mode) |
| fsync_out | output | 1 | Generated frame marker (leader mode) |
| port_drive | output | 1 | Output enable for `bclk_out` and `fsync_out` |
| sdo | output | 1 | Serial data out of the port |
| sdo_oe | output | 1 | Output enable of `sdo` |
| adc_data | input | 16 | Word to transmit, captured at frame start |
| dac_data | output | 16 | Last received word |
| dac_valid | output | 1 | One-cycle strobe when `dac_data` is updated |

## Verification
Two things meet at the first rising edge of a frame. The port captures a new transmit word there, and, when slot 0 is active, it must put that word's MSB on `sdo` at the same edge, not a bit of the old word. The bench changes `adc_data` in the middle of every frame, so the word held from the previous frame always differs from the one due. Each collected serial word is compared with the value sampled when the frame started. In loopback the same captured word must also come back on `dac_data` at the end of the slot, while random `sdi` data is driven to show that the serial input is ignored.

// File: rtl/asp_pkg.sv
package asp_pkg;

    localparam int DEF_DATA_W    = 16;
    localparam int DEF_HALF_BASE = 4;
    localparam int DEF_SYNC_LEN  = 2;

    // divider code to shift amount: 0 -> /1, 1 -> /2, 2 and 3 -> /4
    function automatic logic [1:0] div_shift(input logic [1:0] code);
        logic [1:0] sh;
        case (code)
            2'd0:    sh = 2'd0;
            2'd1:    sh = 2'd1;
            default: sh = 2'd2;
        endcase
        return sh;
    endfunction

endpackage

// File: rtl/asp_bclk_gen.sv
module asp_bclk_gen #(
    parameter int DATA_W    = asp_pkg::DEF_DATA_W,
    parameter int HALF_BASE = asp_pkg::DEF_HALF_BASE
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic [1:0] div_code,
    output logic       bclk,
    output logic       fsync,
    output logic       rise,
    output logic       fall
);
    localparam int FRAME_BITS = 2 * DATA_W;
    localparam int POS_W      = $clog2(FRAME_BITS);
    localparam int CNT_W      = $clog2(HALF_BASE * 4) + 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             bclk;
        logic [POS_W-1:0] pos;
        logic             fsync;
        logic             rise;
        logic             fall;
    } gen_t;

    localparam gen_t GEN_IDLE = '{
        cnt:   '0,
        bclk:  1'b0,
        pos:   POS_W'(FRAME_BITS - 1),
        fsync: 1'b0,
        rise:  1'b0,
        fall:  1'b0
    };

    gen_t q, d;
    logic [CNT_W-1:0] half_len;
    logic [POS_W-1:0] pos_nx;

    always_comb begin
        d        = q;
        d.rise   = 1'b0;
        d.fall   = 1'b0;
        half_len = CNT_W'(HALF_BASE) << asp_pkg::div_shift(div_code);
        pos_nx   = q.pos + POS_W'(1);
        if (!en) begin
            d = GEN_IDLE;
        end else if (q.cnt == half_len - CNT_W'(1)) begin
            d.cnt  = '0;
            d.bclk = ~q.bclk;
            if (!q.bclk) begin
                d.rise  = 1'b1;
                d.pos   = pos_nx;
                d.fsync = (pos_nx < POS_W'(DATA_W));
            end else begin
                d.fall = 1'b1;
            end
        end else begin
            d.cnt = q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= GEN_IDLE;
        else        q <= d;
    end

    assign bclk  = q.bclk;
    assign fsync = q.fsync;
    assign rise  = q.rise;
    assign fall  = q.fall;

endmodule

// File: rtl/asp_sync.sv
module asp_sync #(
    parameter int STAGES = asp_pkg::DEF_SYNC_LEN
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk_raw,
    input  logic fsync_raw,
    input  logic sdi_raw,
    output logic fsync_s,
    output logic sdi_s,
    output logic rise,
    output logic fall
);
    localparam int LANES = 3;

    typedef struct packed {
        logic [STAGES-1:0][LANES-1:0] stg;
        logic                         bclk_prev;
    } sync_t;

    sync_t q, d;
    logic  bclk_s;

    always_comb begin
        d           = q;
        d.stg[0]    = {bclk_raw, fsync_raw, sdi_raw};
        for (int i = 1; i < STAGES; i++) begin
            d.stg[i] = q.stg[i-1];
        end
        d.bclk_prev = q.stg[STAGES-1][2];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign bclk_s  = q.stg[STAGES-1][2];
    assign fsync_s = q.stg[STAGES-1][1];
    assign sdi_s   = q.stg[STAGES-1][0];
    assign rise    = bclk_s & ~q.bclk_prev;
    assign fall    = ~bclk_s & q.bclk_prev;

endmodule

// File: rtl/asp_frame_engine.sv
module asp_frame_engine #(
    parameter int DATA_W = asp_pkg::DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise,
    input  logic              fall,
    input  logic              fsync,
    input  logic              sdi,
    input  logic              long_fs,
    input  logic              slot,
    input  logic              loopback,
    input  logic [DATA_W-1:0] adc_data,
    output logic              sdo,
    output logic              sdo_oe,
    output logic [DATA_W-1:0] dac_data,
    output logic              dac_valid
);
    localparam int FRAME_BITS = 2 * DATA_W;
    localparam int POS_W      = $clog2(FRAME_BITS);
    localparam int IDX_W      = $clog2(DATA_W);

    typedef struct packed {
        logic [POS_W-1:0]  pos;
        logic              locked;
        logic              fs_last;
        logic [DATA_W-1:0] tx;
        logic [DATA_W-1:0] rx;
        logic              sdo;
        logic              oe;
        logic [DATA_W-1:0] dac;
        logic              valid;
    } eng_t;

    eng_t q, d;
    logic              start;
    logic [POS_W-1:0]  pos_nx;
    logic [DATA_W-1:0] tx_word;
    logic [DATA_W-1:0] rx_word;
    logic [IDX_W-1:0]  bit_sel;

    always_comb begin
        d       = q;
        d.valid = 1'b0;
        start   = 1'b0;
        pos_nx  = q.pos;
        tx_word = q.tx;
        rx_word = q.rx;
        bit_sel = '0;
        if (rise) begin
            start     = long_fs ? (fsync & ~q.fs_last) : q.fs_last;
            d.fs_last = fsync;
            if (start) begin
                pos_nx   = '0;
                tx_word  = adc_data;
                d.tx     = adc_data;
                d.locked = 1'b1;
            end else begin
                pos_nx = q.pos + POS_W'(1);
            end
            d.pos   = pos_nx;
            bit_sel = ~pos_nx[IDX_W-1:0];
            d.oe    = (start | q.locked) & (pos_nx[POS_W-1] == slot);
            d.sdo   = d.oe & tx_word[bit_sel];
        end
        if (fall && q.locked && (q.pos[POS_W-1] == slot)) begin
            rx_word = {q.rx[DATA_W-2:0], sdi};
            d.rx    = rx_word;
            if (&q.pos[IDX_W-1:0]) begin
                d.dac   = loopback ? q.tx : rx_word;
                d.valid = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sdo       = q.sdo;
    assign sdo_oe    = q.oe;
    assign dac_data  = q.dac;
    assign dac_valid = q.valid;

endmodule

// File: rtl/audio_serial_port.sv
module audio_serial_port #(
    parameter int DATA_W    = asp_pkg::DEF_DATA_W,
    parameter int HALF_BASE = asp_pkg::DEF_HALF_BASE,
    parameter int SYNC_LEN  = asp_pkg::DEF_SYNC_LEN
) (
    input  logic              mclk,
    input  logic              rst_n,
    input  logic              cfg_master,
    input  logic              cfg_long_fs,
    input  logic              cfg_slot,
    input  logic [1:0]        cfg_div,
    input  logic              cfg_loopback,
    input  logic              bclk_in,
    input  logic              fsync_in,
    input  logic              sdi,
    output logic              bclk_out,
    output logic              fsync_out,
    output logic              port_drive,
    output logic              sdo,
    output logic              sdo_oe,
    input  logic [DATA_W-1:0] adc_data,
    output logic [DATA_W-1:0] dac_data,
    output logic              dac_valid
);
    logic g_bclk, g_fsync, g_rise, g_fall;
    logic s_fsync, s_sdi, s_rise, s_fall;
    logic evt_rise, evt_fall, evt_fsync, long_eff;

    asp_bclk_gen #(.DATA_W(DATA_W), .HALF_BASE(HALF_BASE)) u_gen (
        .clk      (mclk),
        .rst_n    (rst_n),
        .en       (cfg_master),
        .div_code (cfg_div),
        .bclk     (g_bclk),
        .fsync    (g_fsync),
        .rise     (g_rise),
        .fall     (g_fall)
    );

    asp_sync #(.STAGES(SYNC_LEN)) u_sync (
        .clk       (mclk),
        .rst_n     (rst_n),
        .bclk_raw  (bclk_in),
        .fsync_raw (fsync_in),
        .sdi_raw   (sdi),
        .fsync_s   (s_fsync),
        .sdi_s     (s_sdi),
        .rise      (s_rise),
        .fall      (s_fall)
    );

    assign evt_rise  = cfg_master ? g_rise  : s_rise;
    assign evt_fall  = cfg_master ? g_fall  : s_fall;
    assign evt_fsync = cfg_master ? g_fsync : s_fsync;
    assign long_eff  = cfg_master | cfg_long_fs;

    asp_frame_engine #(.DATA_W(DATA_W)) u_eng (
        .clk       (mclk),
        .rst_n     (rst_n),
        .rise      (evt_rise),
        .fall      (evt_fall),
        .fsync     (evt_fsync),
        .sdi       (s_sdi),
        .long_fs   (long_eff),
        .slot      (cfg_slot),
        .loopback  (cfg_loopback),
        .adc_data  (adc_data),
        .sdo       (sdo),
        .sdo_oe    (sdo_oe),
        .dac_data  (dac_data),
        .dac_valid (dac_valid)
    );

    assign bclk_out   = g_bclk;
    assign fsync_out  = g_fsync;
    assign port_drive = cfg_master;

endmodule

// File: rtl/asp_checker.sv
module asp_checker (
    input logic clk,
    input logic rst_n,
    input logic cfg_master,
    input logic bclk_out,
    input logic fsync_out,
    input logic sdo,
    input logic sdo_oe,
    input logic dac_valid,
    input logic rise,
    input logic fall
);
    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        dac_valid |=> !dac_valid); // R4

    AST_VALID_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        dac_valid |-> $past(fall)); // R4

    AST_SDO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rise |=> ($stable(sdo) && $stable(sdo_oe))); // R3

    AST_FOLLOWER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_master |=> (!bclk_out && !fsync_out)); // R10

    AST_MARK_WITH_BCLK: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_master && $rose(fsync_out)) |-> $rose(bclk_out)); // R8

endmodule

bind audio_serial_port asp_checker u_chk (
    .clk        (mclk),
    .rst_n      (rst_n),
    .cfg_master (cfg_master),
    .bclk_out   (bclk_out),
    .fsync_out  (fsync_out),
    .sdo        (sdo),
    .sdo_oe     (sdo_oe),
    .dac_valid  (dac_valid),
    .rise       (evt_rise),
    .fall       (evt_fall)
);

// File: tb/audio_serial_port_bench.sv
`timescale 1ns/1ps
module audio_serial_port_bench;
    localparam int HALF = 8;

    logic        mclk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_master = 1'b0, cfg_long_fs = 1'b0, cfg_slot = 1'b0, cfg_loopback = 1'b0;
    logic [1:0]  cfg_div = 2'd0;
    logic        bclk_in = 1'b0, fsync_in = 1'b0, sdi = 1'b0;
    logic        bclk_out, fsync_out, port_drive, sdo, sdo_oe, dac_valid;
    logic [15:0] adc_data = 16'h0;
    logic [15:0] dac_data;

    int nchk = 0, nerr = 0;
    int phase_id = 0, seen_id = 0;
    string tag = "R3";

    // partner state
    int          cyc = 0, hcnt = 0, ppos = 30;
    logic        pb_prev = 1'b0, pfs_prev = 1'b0, started = 1'b0;
    logic        ev_rise, ev_fall;
    logic [15:0] word0 = 16'h0, word1 = 16'h0, exp_tx = 16'h0, cap = 16'h0;
    logic [15:0] expq[$];
    int          oe_bad = 0, per_bad = 0, frm_bad = 0, fs_bad = 0;
    int          dac_cnt = 0, frames = 0, fs_cnt = 0, last_rise = -1, last_frame = -1;

    audio_serial_port u_audio_serial_port (
        .mclk(mclk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_long_fs(cfg_long_fs),
        .cfg_slot(cfg_slot), .cfg_div(cfg_div), .cfg_loopback(cfg_loopback),
        .bclk_in(bclk_in), .fsync_in(fsync_in), .sdi(sdi), .bclk_out(bclk_out),
        .fsync_out(fsync_out), .port_drive(port_drive), .sdo(sdo), .sdo_oe(sdo_oe),
        .adc_data(adc_data), .dac_data(dac_data), .dac_valid(dac_valid)
    );

    always #2.5 mclk = ~mclk;

    function automatic int divf(input logic [1:0] c);
        return (c == 2'd0) ? 1 : (c == 2'd1) ? 2 : 4;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    // link partner and monitor
    always @(negedge mclk) begin
        cyc++;
        if (phase_id != seen_id) begin
            seen_id = phase_id;
            hcnt = 0; ppos = 30; pb_prev = 1'b0; pfs_prev = 1'b0; started = 1'b0;
            bclk_in = 1'b0; fsync_in = 1'b0; sdi = 1'b0; cap = 16'h0;
            expq.delete();
            oe_bad = 0; per_bad = 0; frm_bad = 0; fs_bad = 0;
            dac_cnt = 0; frames = 0; fs_cnt = 0; last_rise = -1; last_frame = -1;
            adc_data = 16'($urandom);
        end else if (rst_n) begin
            ev_rise = 1'b0;
            ev_fall = 1'b0;
            if (cfg_master) begin
                ev_rise = bclk_out && !pb_prev;
                ev_fall = !bclk_out && pb_prev;
                pb_prev = bclk_out;
            end else begin
                hcnt++;
                if (hcnt == HALF) begin
                    hcnt = 0;
                    bclk_in = ~bclk_in;
                    ev_rise = bclk_in;
                    ev_fall = !bclk_in;
                end
            end
            if (ev_rise) begin
                if (cfg_master) begin
                    if (last_rise >= 0 && (cyc - last_rise) != 8 * divf(cfg_div)) per_bad++;
                    last_rise = cyc;
                    ppos = (fsync_out && !pfs_prev) ? 0 : (ppos + 1) % 32;
                    pfs_prev = fsync_out;
                    if (ppos == 0) begin
                        if (started && fs_cnt != 16) fs_bad++;
                        if (last_frame >= 0 && (cyc - last_frame) != 256 * divf(cfg_div)) frm_bad++;
                        last_frame = cyc;
                        fs_cnt = 0;
                    end
                    if (fsync_out) fs_cnt++;
                end else begin
                    ppos = (ppos + 1) % 32;
                    fsync_in = cfg_long_fs ? (ppos < 16) : (ppos == 31);
                end
                if (ppos == 0) begin
                    started = 1'b1;
                    exp_tx = adc_data;
                    frames++;
                    word0 = 16'($urandom);
                    word1 = 16'($urandom);
                end
                sdi = (ppos < 16) ? word0[15 - ppos] : word1[31 - ppos];
            end
            if (ev_fall && started) begin
                if ((ppos / 16) == int'(cfg_slot)) begin
                    if (!sdo_oe) oe_bad++;
                    cap = {cap[14:0], sdo};
                    if (ppos % 16 == 15) begin
                        chk(cap == exp_tx, tag, int'(cap), int'(exp_tx));
                        expq.push_back(cfg_loopback ? exp_tx : (cfg_slot ? word1 : word0));
                    end
                end else if (sdo_oe) begin
                    oe_bad++;
                end
                if (ppos == 8) adc_data = 16'($urandom);
            end
            if (dac_valid) begin
                dac_cnt++;
                if (expq.size() == 0) begin
                    chk(1'b0, "R4 unexpected strobe", int'(dac_data), 0);
                end else begin
                    chk(dac_data == expq[0], cfg_loopback ? "R9 loopback word" : "R4 receive word",
                        int'(dac_data), int'(expq[0]));
                    void'(expq.pop_front());
                end
            end
        end
    end

    task automatic run_phase(input bit m, input bit l, input bit s, input logic [1:0] dv,
                             input bit lp, input int nfr, input string t);
        int fcyc;
        rst_n = 1'b0;
        cfg_master = m; cfg_long_fs = l; cfg_slot = s; cfg_div = dv; cfg_loopback = lp;
        tag = t;
        phase_id++;
        repeat (4) @(posedge mclk);
        #1;
        chk(!sdo_oe && !dac_valid && !bclk_out && !fsync_out, "R1 reset outputs",
            {sdo_oe, dac_valid, bclk_out, fsync_out}, 0);
        @(negedge mclk);
        rst_n = 1'b1;
        fcyc = m ? 256 * divf(dv) : 64 * HALF;
        repeat (nfr * fcyc + fcyc / 2) @(posedge mclk);
        #1;
        chk(oe_bad == 0, "R2 slot enable", oe_bad, 0);
        chk(dac_cnt >= nfr - 2, "R4 strobe count", dac_cnt, nfr - 2);
        chk(port_drive == m, "R10 drive follows mode", int'(port_drive), int'(m));
        if (m) begin
            chk(per_bad == 0, "R7 bit clock period", per_bad, 0);
            chk(frm_bad == 0 && frames >= nfr - 1, "R8 frame period", frm_bad, 0);
            chk(fs_bad == 0, "R8 marker width", fs_bad, 0);
        end else begin
            chk(!bclk_out && !fsync_out, "R10 follower outputs low", {bclk_out, fsync_out}, 0);
            chk(frames >= nfr - 1, l ? "R6 frames seen" : "R5 frames seen", frames, nfr - 1);
        end
    endtask

    initial begin
        void'($urandom(32'h5A17_C0DE));
        // all-zero controls: follower, short marker, slot 0
        run_phase(1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 8, "R3 R5 short slot0");
        run_phase(1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 8, "R3 R5 short slot1");
        run_phase(1'b0, 1'b1, 1'b0, 2'd0, 1'b0, 8, "R3 R6 long slot0");
        run_phase(1'b0, 1'b1, 1'b1, 2'd0, 1'b0, 8, "R3 R6 long slot1");
        run_phase(1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 8, "R3 R9 loop slot0");
        run_phase(1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 8, "R3 R8 leader div1");
        run_phase(1'b1, 1'b0, 1'b1, 2'd1, 1'b0, 8, "R3 R7 leader div2");
        run_phase(1'b1, 1'b1, 1'b0, 2'd2, 1'b1, 6, "R3 R9 leader div4 loop");
        run_phase(1'b1, 1'b0, 1'b1, 2'd3, 1'b0, 6, "R3 R7 leader code3");
        for (int i = 0; i < 4; i++) begin
            run_phase(1'b0, 1'($urandom), 1'($urandom), 2'd0, 1'($urandom), 6, "R3 random follower");
        end
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge mclk);
        nchk++;
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule